// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles using radix-2 Booth recoding. A single working register of 2N+1 bits carries the running partial product in its upper N bits, the multiplier in the next N bits, and one guard bit below them. The guard bit remembers the multiplier bit that was examined in the previous step. Each iteration looks at the lowest multiplier bit together with the guard bit. It then adds the multiplicand to the upper half, subtracts it, or leaves the upper half alone. Finally it shifts the whole register one place to the right, copying the sign bit into the top.

A caller pulses `start` with the multiplicand on `op_a` and the multiplier on `op_b`. The block raises `busy` for exactly N cycles and then raises `done` for a single cycle. The 2N-bit signed product on `product` stays unchanged until the next accepted start.

The controller has three states. IDLE waits for `start` and loads the register (transition IDLE to CALC). CALC performs one Booth iteration per cycle and moves on after the N-th one (transition CALC to DONE). DONE signals completion for one cycle and always returns to IDLE (transition DONE to IDLE). A `start` seen in CALC or DONE is dropped.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while neither `busy` nor `done` is high makes `busy` high from the next cycle, for exactly WIDTH consecutive cycles.
- R3: `done` rises in the cycle right after the last `busy` cycle, stays high for exactly one cycle, and is never high together with `busy`.
- R4: When `done` is high, `product` equals the 2·WIDTH-bit two's-complement product of the `op_a` and `op_b` values sampled at the accepted start. At WIDTH=4, 2 × 7 gives 8'h0E and 2 × -3 gives 8'hFA.
- R5: The bit pair {current multiplier bit, previous bit} selects the step: 01 adds the multiplicand to the upper half, 10 subtracts it, and 00 and 11 only shift. Multipliers made of runs of ones, alternating bits and all zeros therefore give correct products.
- R6: The upper-half arithmetic keeps one extra sign bit, so the most negative multiplicand times the most negative multiplier gives +2^(2·WIDTH-2). At WIDTH=4 this is 8'h40.
- R7: A `start` pulse while `busy` is high is ignored: the running operation keeps its operands and its timing.
- R8: After `done`, `product` holds its value until the next accepted start.
- R9: Changes on `op_a` and `op_b` outside an accepted start have no effect on the running operation or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; accepted only in IDLE |
| op_a | input | WIDTH | Signed multiplicand |
| op_b | input | WIDTH | Signed multiplier |
| busy | output | 1 | High during the WIDTH iteration cycles |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product, held after completion |

## Verification
The bench builds the block with WIDTH=4. At that width all 256 operand pairs can be swept, so every Booth bit-pair sequence the recoder can meet is covered. The sweep includes the most negative multiplicand against the most negative multiplier, where the extra adder bit matters. A short vector table adds the worked 4-bit cases and pattern multipliers, and directed tests cover ignored starts, operand changes during a run and the hold after completion. The bound checker keeps its window counter sized from the same parameter, so the default WIDTH=16 elaborates with the same properties.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_DONE
    } mult_state_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_ADD,
        OP_SUB
    } booth_op_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic [1:0] pair,
    output booth_op_t  op
);

    // pair = {current multiplier bit, previously examined bit}
    always_comb begin
        unique case (pair)
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mcand,
    input  booth_op_t        op,
    output logic [WIDTH:0]   sum
);

    logic [WIDTH:0] acc_x;
    logic [WIDTH:0] mcand_x;

    // one guard bit so that subtracting the most negative value keeps its sign
    assign acc_x   = {acc[WIDTH-1], acc};
    assign mcand_x = {mcand[WIDTH-1], mcand};

    always_comb begin
        unique case (op)
            OP_ADD:  sum = acc_x + mcand_x;
            OP_SUB:  sum = acc_x - mcand_x;
            default: sum = acc_x;
        endcase
    end

endmodule

// File: rtl/booth_iter_cnt.sv
module booth_iter_cnt #(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int CNT_W = $clog2(STEPS) + 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = step && (cnt_q == CNT_W'(STEPS - 1));

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     op_a,
    input  logic [WIDTH-1:0]     op_b,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);

    localparam int REG_W = 2 * WIDTH + 1;
    localparam int HI_LO = WIDTH + 1;      // lowest bit of the upper half

    mult_state_t      state_q, state_d;
    logic [REG_W-1:0] work_q;
    logic [WIDTH-1:0] mcand_q;
    booth_op_t        step_op;
    logic [WIDTH:0]   step_sum;
    logic             load;
    logic             iter;
    logic             iter_last;

    assign load = (state_q == ST_IDLE) && start;
    assign iter = (state_q == ST_CALC);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_CALC;
            ST_CALC: if (iter_last) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state_q == ST_CALC);
        done    = (state_q == ST_DONE);
        product = work_q[REG_W-1:1];
    end

    booth_recode u_recode (
        .pair (work_q[1:0]),
        .op   (step_op)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc   (work_q[REG_W-1:HI_LO]),
        .mcand (mcand_q),
        .op    (step_op),
        .sum   (step_sum)
    );

    booth_iter_cnt #(.STEPS(WIDTH)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (iter),
        .last  (iter_last)
    );

    // working register: {partial product, multiplier, previous bit}
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q  <= '0;
            mcand_q <= '0;
        end else if (load) begin
            work_q  <= {{WIDTH{1'b0}}, op_b, 1'b0};
            mcand_q <= op_a;
        end else if (iter) begin
            // the (WIDTH+1)-bit sum supplies the replicated sign on the shift
            work_q  <= {step_sum, work_q[WIDTH:1]};
        end
    end

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int WIDTH = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);

    localparam int RUN_W = $clog2(WIDTH) + 2;

    logic [RUN_W-1:0]          run_q;
    logic signed [WIDTH-1:0]   a_q;
    logic signed [WIDTH-1:0]   b_q;
    logic signed [2*WIDTH-1:0] expect_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (start && !busy && !done) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    assign expect_w = a_q * b_q;

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(WIDTH)));

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    p_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == expect_w));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && !done)) |=> $stable(product));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_seq_mult_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mult_tb_top;

    localparam int W  = 4;
    localparam int PW = 2 * W;
    localparam int NV = 10;

    // {op_a, op_b, expected product}
    localparam logic [15:0] VECS [NV] = '{
        16'h270E,   // 2 x 7 = 14          R4
        16'h2DFA,   // 2 x -3 = -6         R4
        16'h8840,   // -8 x -8 = 64        R6
        16'h87C8,   // -8 x 7 = -56        R6
        16'h7731,   // 7 x 7 = 49          R5 run of ones
        16'hFF01,   // -1 x -1 = 1         R5 all ones
        16'h5000,   // 5 x 0 = 0           R5 all zeros
        16'h0800,   // 0 x -8 = 0          R5
        16'h350F,   // 3 x 5 = 15          R5 alternating
        16'h9931    // -7 x -7 = 49        R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    booth_seq_mult #(.WIDTH(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // wait for done after the start-drop negedge; returns negedges counted
    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [PW-1:0] exp, input string req);
        int cyc;
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
        wait_done(cyc);
        chk(cyc == W + 1, "R3 done timing", 32'(cyc), 32'(W + 1));
        chk(product == exp, req, 32'(product), 32'(exp));
        chk(busy == 1'b0, "R3 busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R3 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cyc;
        logic [PW-1:0] held;

        // R1 reset state
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", 32'({busy, done}), 32'd0);
        chk(product == '0, "R1 product in reset", 32'(product), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after reset",
            32'({busy, done, product}), 32'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            run_mult(VECS[v][15:12], VECS[v][11:8], VECS[v][7:0], "R4 R5 R6 table product");
        end

        // exhaustive sweep at WIDTH=4
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                logic signed [W-1:0]  sa;
                logic signed [W-1:0]  sb;
                logic signed [PW-1:0] se;
                sa = W'(i);
                sb = W'(j);
                se = sa * sb;
                run_mult(sa, sb, se, "R4 R5 R6 sweep product");
            end
        end

        // R7 start while busy ignored, R9 operand changes ignored
        @(negedge clk);
        start = 1'b1; op_a = 4'h3; op_b = 4'hE;       // 3 x -2 = -6
        @(negedge clk);
        start = 1'b0;
        op_a = 4'h7; op_b = 4'h7;                     // R9 change during run
        @(negedge clk);
        start = 1'b1;                                 // R7 pulse while busy
        @(negedge clk);
        start = 1'b0; op_a = 4'h8; op_b = 4'h8;
        cyc = 3;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == W + 1, "R7 timing kept with start while busy", 32'(cyc), 32'(W + 1));
        chk(product == 8'hFA, "R7 R9 product unaffected", 32'(product), 32'hFA);
        held = product;

        // R8 hold after done while inputs move
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op_a = W'(k); op_b = W'(k + 5);
        end
        chk(busy == 1'b0 && done == 1'b0, "R8 idle after done", 32'({busy, done}), 32'd0);
        chk(product == held, "R8 product held", 32'(product), 32'(held));

        // back-to-back operation after idle still works
        run_mult(4'h2, 4'h7, 8'h0E, "R4 repeat after hold");

        finish_run();
    end

endmodule